// File: doc/BRIEF.md
# Speculative Trace Checkpoint Controller

This block holds architectural register state for a wide-issue core that runs compiler-formed speculative traces. Each trace carries its condition checks at its tail rather than at the branch points inside it. When a tail check passes, the whole primary register file is copied into a committed snapshot in one cycle. When a tail check fails, the core rolls back to that snapshot.

Two hardware register contexts are kept. When a decision tree starts, the most probable trace (rank 0) runs as the primary context. The next trace by descending probability is parked in the secondary context. While the primary is stalled on a cache miss or page fault, the secondary context accepts writes, so the next-probable trace makes progress. On a failed check, the secondary context is promoted to primary and keeps its progress. The old primary file is reloaded from the snapshot and takes the next untried rank. On a passed check, the secondary's partial work is abandoned.

The core observes the three register images through one read address. Status outputs report the primary and secondary ranks and whether the secondary is busy. Two counters report the number of mispredictions and the number of stall cycles that were overlapped with secondary execution.

Top module: `tckp_ctrl`

## Requirements
- R1: After reset, all three register images read zero, `pri_rank` is 0, `sec_busy` is 0, and both counters are 0.
- R2: A `tree_start` with `chk_valid` low takes effect at the next clock edge. The primary rank becomes 0 and both contexts are loaded from the snapshot. If `tree_traces` is greater than 1, `sec_busy` becomes 1 and `sec_rank` becomes 1; otherwise the secondary stays idle.
- R3: A primary write (`p_we`) updates the primary image at the next edge only when `stall`, `chk_valid` and `tree_start` are all low. In any other cycle the write is ignored.
- R4: A secondary write (`s_we`) is accepted only when `sec_busy`, `stall` and no check or tree start are present in the same cycle. It lands only in the secondary image. The snapshot changes only on a passed check.
- R5: A passed check (`chk_valid`=1, `chk_pass`=1) copies the primary image into the snapshot at the next edge and makes `sec_busy` 0.
- R6: A failed check while the secondary is busy promotes it. `pri_rank` takes the old `sec_rank`, and the primary image shows the secondary's written values. The demoted file is reloaded from the snapshot. It receives the next untried rank, or goes idle if every rank of the tree has already been handed out.
- R7: A failed check with the secondary idle restores the primary image from the snapshot in one cycle. `pri_rank` advances to the next untried rank if one remains and otherwise keeps its value.
- R8: When a check and a stall fall in the same cycle, the check is acted on and the stall is dropped. No secondary write is taken and the overlap counter does not move.
- R9: When the secondary is idle, a stall only freezes the primary image, and the overlap counter does not move.
- R10: `mispred_cnt` increases by 1 on every failed check. `overlap_cnt` increases by 1 on every stall cycle in which the secondary context runs. Both counters saturate at their maximum value.
- R11: When `tree_start` and `chk_valid` are high in the same cycle, the check is acted on and the tree start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tree_start | input | 1 | Begin a new decision tree |
| tree_traces | input | RANKW+1 | Number of traces in the new tree |
| p_we | input | 1 | Primary context write enable |
| p_waddr | input | AW | Primary write register index |
| p_wdata | input | DW | Primary write data |
| s_we | input | 1 | Secondary context write enable |
| s_waddr | input | AW | Secondary write register index |
| s_wdata | input | DW | Secondary write data |
| stall | input | 1 | Primary trace stalled on memory |
| chk_valid | input | 1 | Tail check resolves this cycle |
| chk_pass | input | 1 | Tail check outcome, 1 = pass |
| rd_addr | input | AW | Read register index for all images |
| rd_pri | output | DW | Primary image at rd_addr |
| rd_sec | output | DW | Secondary image at rd_addr |
| rd_ckpt | output | DW | Snapshot image at rd_addr |
| pri_rank | output | RANKW | Probability rank of the primary trace |
| sec_rank | output | RANKW | Probability rank of the secondary trace |
| sec_busy | output | 1 | Secondary context holds a live trace |
| mispred_cnt | output | CNTW | Failed check count |
| overlap_cnt | output | CNTW | Overlapped stall cycle count |

## Verification
The bench targets cycles where two events coincide. A check in the same cycle as a stall must not take a secondary write, and a design that got this wrong would bump the overlap count or corrupt the soon-to-be-primary file. A check together with a tree start must not restart the ranks, and a wrong design would reset `pri_rank` and revive the secondary. Promotion is checked by data: a design that restarted the trace instead of promoting it would show snapshot values where the secondary's writes should appear. The bench also runs a single-trace tree and a tree whose ranks have all been handed out, where a wrong design would count phantom overlap or would let the rank run past the last trace.

// File: rtl/tckp_pkg.sv
package tckp_pkg;
   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_PASS = 2'd1,
      EV_FAIL = 2'd2
   } chk_ev_e;
endpackage

// File: rtl/tckp_regfile.sv
module tckp_regfile #(
   parameter int NREG = 8,
   parameter int DW   = 32,
   localparam int AW  = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [NREG-1:0][DW-1:0]   load_data,
   input  logic                      we,
   input  logic [AW-1:0]             waddr,
   input  logic [DW-1:0]             wdata,
   output logic [NREG-1:0][DW-1:0]   q
);
   // bulk load wins over a single-entry write
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_data;
      else if (we)   q[waddr] <= wdata;
   end

   a_r4_idle_file_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !we) |=> $stable(q));
endmodule

// File: rtl/tckp_seq.sv
module tckp_seq
   import tckp_pkg::*;
#(
   parameter int RANKW = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  chk_ev_e          ev,
   input  logic             tree_go,
   input  logic [RANKW:0]   tree_cnt,
   output logic             pri_sel,
   output logic [RANKW-1:0] pri_rank,
   output logic [RANKW-1:0] sec_rank,
   output logic             sec_busy,
   output logic             restore,
   output logic             fill_both
);
   localparam logic [RANKW:0]   ONE_W  = (RANKW+1)'(1);
   localparam logic [RANKW:0]   TWO_W  = (RANKW+1)'(2);
   localparam logic [RANKW-1:0] RANK1  = RANKW'(1);

   logic [RANKW:0] next_q;
   logic [RANKW:0] cnt_q;
   logic           more;

   assign more      = (next_q < cnt_q);
   assign restore   = (ev == EV_FAIL);
   assign fill_both = tree_go && (ev == EV_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pri_sel  <= 1'b0;
         pri_rank <= '0;
         sec_rank <= '0;
         sec_busy <= 1'b0;
         next_q   <= '0;
         cnt_q    <= '0;
      end else begin
         unique case (ev)
            EV_PASS: sec_busy <= 1'b0;
            EV_FAIL: begin
               if (sec_busy) begin
                  pri_sel  <= ~pri_sel;
                  pri_rank <= sec_rank;
                  if (more) begin
                     sec_rank <= next_q[RANKW-1:0];
                     next_q   <= next_q + ONE_W;
                  end else begin
                     sec_busy <= 1'b0;
                  end
               end else if (more) begin
                  pri_rank <= next_q[RANKW-1:0];
                  next_q   <= next_q + ONE_W;
               end
            end
            default: begin
               if (tree_go) begin
                  pri_rank <= '0;
                  cnt_q    <= tree_cnt;
                  if (tree_cnt > ONE_W) begin
                     sec_busy <= 1'b1;
                     sec_rank <= RANK1;
                     next_q   <= TWO_W;
                  end else begin
                     sec_busy <= 1'b0;
                     next_q   <= ONE_W;
                  end
               end
            end
         endcase
      end
   end

   a_r6_promote_rank: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_FAIL && sec_busy) |=> (pri_rank == $past(sec_rank)));
   a_r5_pass_idles_sec: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_PASS) |=> !sec_busy);
   a_r11_check_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (tree_go && ev != EV_NONE) |=> $stable(cnt_q));
   a_r7_rank_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_FAIL && !sec_busy && !more) |=> $stable(pri_rank));
endmodule

// File: rtl/tckp_cnt.sv
module tckp_cnt #(
   parameter int W   = 16,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] TOPV = '1;

   generate
      if (SAT) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)                  q <= '0;
            else if (inc && q != TOPV)   q <= q + ONE;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)   q <= '0;
            else if (inc) q <= q + ONE;
         end
      end
   endgenerate

   a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && q != TOPV) |=> (q == $past(q) + ONE));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(q));
endmodule

// File: rtl/tckp_ctrl.sv
module tckp_ctrl
   import tckp_pkg::*;
#(
   parameter int NREG    = 8,
   parameter int DW      = 32,
   parameter int RANKW   = 3,
   parameter int CNTW    = 16,
   parameter bit SAT_CNT = 1'b1,
   localparam int AW     = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tree_start,
   input  logic [RANKW:0]   tree_traces,
   input  logic             p_we,
   input  logic [AW-1:0]    p_waddr,
   input  logic [DW-1:0]    p_wdata,
   input  logic             s_we,
   input  logic [AW-1:0]    s_waddr,
   input  logic [DW-1:0]    s_wdata,
   input  logic             stall,
   input  logic             chk_valid,
   input  logic             chk_pass,
   input  logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_pri,
   output logic [DW-1:0]    rd_sec,
   output logic [DW-1:0]    rd_ckpt,
   output logic [RANKW-1:0] pri_rank,
   output logic [RANKW-1:0] sec_rank,
   output logic             sec_busy,
   output logic [CNTW-1:0]  mispred_cnt,
   output logic [CNTW-1:0]  overlap_cnt
);
   generate
      if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
         $error("tckp_ctrl: NREG must be a power of two of at least 2");
      end
      if (RANKW < 1 || DW < 1 || CNTW < 1) begin : g_bad_width
         $error("tckp_ctrl: RANKW, DW and CNTW must be positive");
      end
   endgenerate

   chk_ev_e ev;
   logic    pri_sel, restore, fill_both;
   logic    p_ok, s_ok, ovl_tick, fail_tick;

   logic [NREG-1:0][DW-1:0] ctx_q [2];
   logic [NREG-1:0][DW-1:0] ckpt_q;

   always_comb begin
      if (!chk_valid)    ev = EV_NONE;
      else if (chk_pass) ev = EV_PASS;
      else               ev = EV_FAIL;
   end

   // a check or tree start in the cycle blocks writes and drops the stall
   assign p_ok      = p_we & ~stall & ~chk_valid & ~tree_start;
   assign ovl_tick  = sec_busy & stall & ~chk_valid & ~tree_start;
   assign s_ok      = s_we & ovl_tick;
   assign fail_tick = (ev == EV_FAIL);

   tckp_seq #(.RANKW(RANKW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .tree_go  (tree_start),
      .tree_cnt (tree_traces),
      .pri_sel  (pri_sel),
      .pri_rank (pri_rank),
      .sec_rank (sec_rank),
      .sec_busy (sec_busy),
      .restore  (restore),
      .fill_both(fill_both)
   );

   // two physical contexts; pri_sel names the one acting as primary
   generate
      for (genvar g = 0; g < 2; g++) begin : g_ctx
         logic          is_pri;
         logic          ld, wr;
         logic [AW-1:0] wa;
         logic [DW-1:0] wd;
         assign is_pri = (pri_sel == 1'(g));
         assign ld     = fill_both | (restore & is_pri);
         assign wr     = is_pri ? p_ok    : s_ok;
         assign wa     = is_pri ? p_waddr : s_waddr;
         assign wd     = is_pri ? p_wdata : s_wdata;
         tckp_regfile #(.NREG(NREG), .DW(DW)) u_file (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld),
            .load_data(ckpt_q),
            .we       (wr),
            .waddr    (wa),
            .wdata    (wd),
            .q        (ctx_q[g])
         );
      end
   endgenerate

   tckp_regfile #(.NREG(NREG), .DW(DW)) u_ckpt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ev == EV_PASS),
      .load_data(ctx_q[pri_sel]),
      .we       (1'b0),
      .waddr    ('0),
      .wdata    ('0),
      .q        (ckpt_q)
   );

   tckp_cnt #(.W(CNTW), .SAT(SAT_CNT)) u_mis (
      .clk(clk), .rst_n(rst_n), .inc(fail_tick), .q(mispred_cnt));

   tckp_cnt #(.W(CNTW), .SAT(SAT_CNT)) u_ovl (
      .clk(clk), .rst_n(rst_n), .inc(ovl_tick), .q(overlap_cnt));

   assign rd_pri  = ctx_q[pri_sel][rd_addr];
   assign rd_sec  = ctx_q[~pri_sel][rd_addr];
   assign rd_ckpt = ckpt_q[rd_addr];

   a_r4_ckpt_only_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
      !(chk_valid && chk_pass) |=> $stable(ckpt_q));
   a_r8_check_drops_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && stall) |=> $stable(overlap_cnt));
   a_r9_idle_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_busy |=> $stable(overlap_cnt));
endmodule

// File: tb/tckp_ctrl_tb.sv
module tckp_ctrl_tb;
   localparam int NREG = 8, DW = 32, RANKW = 3, CNTW = 16, AW = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic tree_start;
   logic [RANKW:0] tree_traces;
   logic p_we, s_we, stall, chk_valid, chk_pass;
   logic [AW-1:0] p_waddr, s_waddr, rd_addr;
   logic [DW-1:0] p_wdata, s_wdata;
   logic [DW-1:0] rd_pri, rd_sec, rd_ckpt;
   logic [RANKW-1:0] pri_rank, sec_rank;
   logic sec_busy;
   logic [CNTW-1:0] mispred_cnt, overlap_cnt;

   int n_chk = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   tckp_ctrl #(.NREG(NREG), .DW(DW), .RANKW(RANKW), .CNTW(CNTW)) u_dut (
      .clk, .rst_n, .tree_start, .tree_traces, .p_we, .p_waddr, .p_wdata,
      .s_we, .s_waddr, .s_wdata, .stall, .chk_valid, .chk_pass, .rd_addr,
      .rd_pri, .rd_sec, .rd_ckpt, .pri_rank, .sec_rank, .sec_busy,
      .mispred_cnt, .overlap_cnt);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_in();
      tree_start = 0; tree_traces = '0; p_we = 0; s_we = 0; stall = 0;
      chk_valid = 0; chk_pass = 0; p_waddr = '0; s_waddr = '0;
      p_wdata = '0; s_wdata = '0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      idle_in();
   endtask

   task automatic peek(input logic [AW-1:0] a);
      rd_addr = a;
      #0.5;
   endtask

   task automatic t_reset();
      peek(3);
      check("R1 pri", 64'(rd_pri), 0);
      check("R1 ckpt", 64'(rd_ckpt), 0);
      check("R1 rank", 64'(pri_rank), 0);
      check("R1 busy", 64'(sec_busy), 0);
      check("R1 mis", 64'(mispred_cnt), 0);
      check("R1 ovl", 64'(overlap_cnt), 0);
   endtask

   task automatic t_tree3();
      tree_start = 1; tree_traces = 3; step();
      check("R2 pri_rank", 64'(pri_rank), 0);
      check("R2 sec_busy", 64'(sec_busy), 1);
      check("R2 sec_rank", 64'(sec_rank), 1);
   endtask

   task automatic t_pwrite();
      p_we = 1; p_waddr = 1; p_wdata = 32'h11; step();
      peek(1); check("R3 write lands", 64'(rd_pri), 64'h11);
      p_we = 1; p_waddr = 2; p_wdata = 32'hBAD; stall = 1; s_we = 0; step();
      peek(2); check("R3 stalled write ignored", 64'(rd_pri), 0);
   endtask

   task automatic t_overlap();
      // the earlier stall cycle already counted one overlap
      stall = 1; s_we = 1; s_waddr = 1; s_wdata = 32'h22; step();
      stall = 1; s_we = 1; s_waddr = 5; s_wdata = 32'h55; step();
      peek(5); check("R4 sec write", 64'(rd_sec), 64'h55);
      peek(1); check("R4 sec r1", 64'(rd_sec), 64'h22);
      check("R4 pri untouched", 64'(rd_pri), 64'h11);
      check("R4 ckpt untouched", 64'(rd_ckpt), 0);
      check("R10 overlap count", 64'(overlap_cnt), 3);
   endtask

   task automatic t_promote();
      chk_valid = 1; chk_pass = 0; step();
      check("R6 pri_rank", 64'(pri_rank), 1);
      peek(5); check("R6 progress kept", 64'(rd_pri), 64'h55);
      check("R6 demoted reloaded", 64'(rd_sec), 0);
      check("R6 next sec_rank", 64'(sec_rank), 2);
      check("R6 sec_busy", 64'(sec_busy), 1);
      check("R10 mis", 64'(mispred_cnt), 1);
   endtask

   task automatic t_collide_stall();
      chk_valid = 1; chk_pass = 0; stall = 1; s_we = 1; s_waddr = 7; s_wdata = 32'h77; step();
      check("R8 ovl unchanged", 64'(overlap_cnt), 3);
      check("R8 mis", 64'(mispred_cnt), 2);
      check("R6 ranks exhausted", 64'(sec_busy), 0);
      check("R6 rank2", 64'(pri_rank), 2);
      peek(7); check("R8 no sec write", 64'(rd_pri), 0);
   endtask

   task automatic t_fail_nosec();
      p_we = 1; p_waddr = 3; p_wdata = 32'h33; step();
      chk_valid = 1; chk_pass = 0; step();
      peek(3); check("R7 restore", 64'(rd_pri), 0);
      check("R7 rank held", 64'(pri_rank), 2);
      check("R10 mis3", 64'(mispred_cnt), 3);
   endtask

   task automatic t_stall_idle();
      stall = 1; p_we = 1; p_waddr = 4; p_wdata = 32'hDEAD; step();
      peek(4); check("R9 frozen", 64'(rd_pri), 0);
      check("R9 ovl", 64'(overlap_cnt), 3);
   endtask

   task automatic t_pass();
      p_we = 1; p_waddr = 4; p_wdata = 32'h44; step();
      chk_valid = 1; chk_pass = 1; step();
      peek(4); check("R5 snapshot", 64'(rd_ckpt), 64'h44);
      check("R5 sec idle", 64'(sec_busy), 0);
   endtask

   task automatic t_tree_vs_chk();
      tree_start = 1; tree_traces = 3; chk_valid = 1; chk_pass = 1; step();
      check("R11 tree dropped busy", 64'(sec_busy), 0);
      check("R11 tree dropped rank", 64'(pri_rank), 2);
   endtask

   task automatic t_single();
      tree_start = 1; tree_traces = 1; step();
      check("R2 single rank", 64'(pri_rank), 0);
      check("R2 single idle", 64'(sec_busy), 0);
      peek(4); check("R2 sec loaded", 64'(rd_sec), 64'h44);
      stall = 1; s_we = 1; s_waddr = 4; s_wdata = 32'h99; step();
      stall = 1; step();
      check("R9 single ovl", 64'(overlap_cnt), 3);
      peek(4); check("R4 idle sec write dropped", 64'(rd_sec), 64'h44);
   endtask

   task automatic t_tree4();
      tree_start = 1; tree_traces = 4; step();
      chk_valid = 1; chk_pass = 0; step();
      check("R6 tree4 pri", 64'(pri_rank), 1);
      check("R6 tree4 sec", 64'(sec_rank), 2);
      check("R10 mis4", 64'(mispred_cnt), 4);
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      idle_in(); rd_addr = '0; rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_tree3();
      t_pwrite();
      t_overlap();
      t_promote();
      t_collide_stall();
      t_fail_nosec();
      t_stall_idle();
      t_pass();
      t_tree_vs_chk();
      t_single();
      t_tree4();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule